// File: doc/BRIEF.md
# SDRAM Refresh and Self-Refresh Manager

This block keeps an SDR SDRAM's contents alive. An interval timer, sized from the clock frequency, counts the clocks between auto-refresh operations. Each time it expires it owes one refresh, and it raises a request to the command sequencer that shares the SDRAM command bus. When the sequencer grants, the block takes the bus. It drives one CBR refresh command, then holds NOPs for the row cycle time before it hands the bus back. A pending refresh wins over a low-power request at the same grant.

If a whole second interval expires while a refresh is still owed, the block flags the deadline as missed. At the next grant it then performs two back-to-back refreshes without releasing the bus, and the flag clears once both are done. When the host asks for low power and no refresh is owed, the block enters self refresh: a refresh command with CKE dropped in the same cycle. It holds CKE low until the request falls, then raises CKE and keeps NOPs on the bus for the refresh cycle time before it lets go. The interval timer is frozen while the device refreshes itself and starts again from a full interval afterwards.

Top module: `sdram_refresh_mgr`

## Requirements
- R1: While reset is asserted and in the first cycle after it: ref_req=0, bus_own=0, sdr_cke=1, refresh_late=0, and sdr_cmd is NOP (encoding {cs_n,ras_n,cas_n,we_n} = 4'b0111).
- R2: After reset release, ref_req first reads 1 after exactly TREFI_CLKS rising edges.
- R3: While a refresh is owed and no grant has arrived, ref_req stays 1, bus_own stays 0 and sdr_cmd stays NOP.
- R4: A grant taken while ref_req=1 with a refresh owed makes the next cycle carry the refresh command (4'b0001) with sdr_cke=1 and bus_own=1.
- R5: Each refresh command is followed by NOPs, and bus_own stays 1 for exactly TRFC_CLKS cycles per refresh, counting the command cycle.
- R6: If a second interval expires while a refresh is still owed, refresh_late becomes 1. The next grant then yields exactly two refresh commands within one bus ownership of 2*TRFC_CLKS cycles, and refresh_late is 0 after the release.
- R7: When a refresh is owed and lp_req=1 at the grant, the refresh (with sdr_cke=1) is performed first.
- R8: A grant with lp_req=1 and no refresh owed yields one cycle of refresh command with sdr_cke=0. sdr_cke then stays 0 with NOPs and bus_own=1 while lp_req stays 1.
- R9: After lp_req falls in self refresh, sdr_cke returns to 1 and the block drives NOPs with bus_own=1 for exactly TRFC_CLKS cycles, then releases.
- R10: During self refresh ref_req stays 0 and the interval timer is held. After the release, ref_req first reads 1 after exactly TREFI_CLKS further edges.
- R11: A grant while ref_req=0 is ignored: bus_own stays 0 and sdr_cmd stays NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| lp_req | input | 1 | Host asks for self refresh while high; falling starts exit |
| ref_gnt | input | 1 | Sequencer hands the command bus to this block |
| ref_req | output | 1 | Refresh owed or low-power entry wanted; needs a grant |
| bus_own | output | 1 | This block is driving the SDRAM command bus |
| sdr_cke | output | 1 | SDRAM clock enable |
| sdr_cmd | output | 4 | SDRAM command {cs_n,ras_n,cas_n,we_n} |
| refresh_late | output | 1 | A refresh deadline was missed; recovery pair owed |

## Verification
The assertions assume the sequencer grants only while ref_req is high and the bus is idle. They also assume a grant is a single-cycle pulse, and that lp_req stays steady from the grant until self refresh is reached. The stimulus pulses ref_gnt for one cycle. It raises lp_req only while the bus is idle and holds it until the cke-low phase is observed. The one deliberate stray grant falls at a time when no request is up, which exercises the ignore rule. Grant delays are chosen so that no interval expiry coincides with a refresh in flight, except in the case built to overrun.

// File: rtl/sdram_ref_pkg.sv
package sdram_ref_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_RFSH    = 3'd1,
        ST_RCWAIT  = 3'd2,
        ST_SRENTER = 3'd3,
        ST_SRHOLD  = 3'd4,
        ST_SREXIT  = 3'd5
    } mgr_state_e;

    // {cs_n, ras_n, cas_n, we_n}
    typedef logic [3:0] sdr_cmd_t;
    localparam sdr_cmd_t CMD_NOP  = 4'b0111;
    localparam sdr_cmd_t CMD_AREF = 4'b0001;

endpackage

// File: rtl/sdram_ref_interval.sv
module sdram_ref_interval #(
    parameter int unsigned TREFI_CLKS = 1562
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic take,
    output logic pending,
    output logic late
);
    localparam int unsigned CW = (TREFI_CLKS > 2) ? $clog2(TREFI_CLKS) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(TREFI_CLKS - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [1:0]    owed;
        logic          late;
    } ivl_t;

    ivl_t ivl_d, ivl_q;
    logic tick;
    logic [1:0] base;

    always_comb begin
        ivl_d = ivl_q;
        tick  = 1'b0;
        base  = ivl_q.owed;
        if (hold) begin
            ivl_d.cnt  = RELOAD;
            ivl_d.owed = 2'd0;
            ivl_d.late = 1'b0;
        end else begin
            if (ivl_q.cnt == '0) begin
                tick      = 1'b1;
                ivl_d.cnt = RELOAD;
            end else begin
                ivl_d.cnt = ivl_q.cnt - 1'b1;
            end
            if (take && ivl_q.owed != 2'd0) begin
                base = ivl_q.owed - 2'd1;
            end
            if (tick) begin
                if (base != 2'd0) begin
                    ivl_d.owed = 2'd2;
                    ivl_d.late = 1'b1;
                end else begin
                    ivl_d.owed = 2'd1;
                end
            end else begin
                ivl_d.owed = base;
            end
            if (ivl_d.owed == 2'd0) begin
                ivl_d.late = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ivl_q <= '{cnt: RELOAD, owed: 2'd0, late: 1'b0};
        end else begin
            ivl_q <= ivl_d;
        end
    end

    assign pending = (ivl_q.owed != 2'd0);
    assign late    = ivl_q.late;

    assert_owed_max_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ivl_q.owed != 2'd3);

    assert_late_means_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ivl_q.late) |-> ivl_q.owed == 2'd2);

endmodule

// File: rtl/sdram_ref_window.sv
module sdram_ref_window #(
    parameter int unsigned MAX_CLKS = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         load,
    input  logic [$clog2(MAX_CLKS+1)-1:0] load_val,
    output logic                         zero
);
    localparam int unsigned WW = $clog2(MAX_CLKS + 1);

    logic [WW-1:0] win_d, win_q;

    always_comb begin
        win_d = win_q;
        if (load) begin
            win_d = load_val;
        end else if (win_q != '0) begin
            win_d = win_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q <= '0;
        end else begin
            win_q <= win_d;
        end
    end

    assign zero = (win_q == '0);

    assert_no_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (zero && !load) |=> zero);

endmodule

// File: rtl/sdram_refresh_mgr.sv
module sdram_refresh_mgr
    import sdram_ref_pkg::*;
#(
    parameter int unsigned TREFI_CLKS = 1562,
    parameter int unsigned TRFC_CLKS  = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lp_req,
    input  logic       ref_gnt,
    output logic       ref_req,
    output logic       bus_own,
    output logic       sdr_cke,
    output logic [3:0] sdr_cmd,
    output logic       refresh_late
);
    localparam int unsigned WW = $clog2(TRFC_CLKS + 1);
    localparam logic [WW-1:0] RC_LOAD = WW'(TRFC_CLKS - 2);
    localparam logic [WW-1:0] XS_LOAD = WW'(TRFC_CLKS - 1);

    typedef struct packed {
        mgr_state_e state;
    } mgr_t;

    mgr_t mgr_d, mgr_q;

    logic          owed;
    logic          take;
    logic          hold;
    logic          win_load;
    logic [WW-1:0] win_val;
    logic          win_zero;

    sdram_ref_interval #(.TREFI_CLKS(TREFI_CLKS)) u_interval (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold    (hold),
        .take    (take),
        .pending (owed),
        .late    (refresh_late)
    );

    sdram_ref_window #(.MAX_CLKS(TRFC_CLKS)) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (win_load),
        .load_val (win_val),
        .zero     (win_zero)
    );

    always_comb begin
        mgr_d    = mgr_q;
        win_load = 1'b0;
        win_val  = RC_LOAD;
        case (mgr_q.state)
            ST_IDLE: begin
                if (ref_gnt && (owed || lp_req)) begin
                    mgr_d.state = owed ? ST_RFSH : ST_SRENTER;
                end
            end
            ST_RFSH: begin
                win_load    = 1'b1;
                win_val     = RC_LOAD;
                mgr_d.state = ST_RCWAIT;
            end
            ST_RCWAIT: begin
                if (win_zero) begin
                    mgr_d.state = owed ? ST_RFSH : ST_IDLE;
                end
            end
            ST_SRENTER: mgr_d.state = ST_SRHOLD;
            ST_SRHOLD: begin
                if (!lp_req) begin
                    win_load    = 1'b1;
                    win_val     = XS_LOAD;
                    mgr_d.state = ST_SREXIT;
                end
            end
            ST_SREXIT: begin
                if (win_zero) begin
                    mgr_d.state = ST_IDLE;
                end
            end
            default: mgr_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mgr_q <= '{state: ST_IDLE};
        end else begin
            mgr_q <= mgr_d;
        end
    end

    assign take    = (mgr_q.state == ST_RFSH);
    assign hold    = (mgr_q.state == ST_SRENTER) || (mgr_q.state == ST_SRHOLD) ||
                     (mgr_q.state == ST_SREXIT);
    assign bus_own = (mgr_q.state != ST_IDLE);
    assign sdr_cke = !((mgr_q.state == ST_SRENTER) || (mgr_q.state == ST_SRHOLD));
    assign sdr_cmd = ((mgr_q.state == ST_RFSH) || (mgr_q.state == ST_SRENTER)) ? CMD_AREF : CMD_NOP;
    assign ref_req = (mgr_q.state == ST_IDLE) && (owed || lp_req);

    assert_cke_low_owned_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !sdr_cke |-> bus_own);

    assert_aref_then_nop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sdr_cmd == CMD_AREF) |=> (sdr_cmd == CMD_NOP) && bus_own);

    assert_stray_grant_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_gnt && !ref_req && !bus_own) |=> !bus_own);

    assert_no_req_in_sr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !sdr_cke |-> !ref_req);

    assert_cke_rise_nop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdr_cke) |-> (sdr_cmd == CMD_NOP) && bus_own);

    assert_req_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req |-> !bus_own);

endmodule

// File: tb/sdram_refresh_mgr_bench.sv
module sdram_refresh_mgr_bench;
    localparam int unsigned TREFI = 40;
    localparam int unsigned TRFC  = 5;
    localparam logic [3:0] NOP  = 4'b0111;
    localparam logic [3:0] AREF = 4'b0001;

    typedef struct packed {
        logic [15:0] dly;
        logic [3:0]  nref;
        logic        miss;
    } vec_t;

    // grant delay after request, refreshes expected, late flag expected at grant
    localparam vec_t VEC [5] = '{
        '{16'd0,          4'd1, 1'b0},
        '{16'd3,          4'd1, 1'b0},
        '{16'(TREFI + 5), 4'd2, 1'b1},
        '{16'd12,         4'd1, 1'b0},
        '{16'd30,         4'd1, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lp_req = 1'b0;
    logic ref_gnt = 1'b0;
    logic ref_req, bus_own, sdr_cke, refresh_late;
    logic [3:0] sdr_cmd;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    sdram_refresh_mgr #(.TREFI_CLKS(TREFI), .TRFC_CLKS(TRFC)) u_sdram_refresh_mgr (
        .clk(clk), .rst_n(rst_n), .lp_req(lp_req), .ref_gnt(ref_gnt),
        .ref_req(ref_req), .bus_own(bus_own), .sdr_cke(sdr_cke),
        .sdr_cmd(sdr_cmd), .refresh_late(refresh_late)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic own_span(output int cyc, output int nr, output int cke_bad);
        cyc = 0; nr = 0; cke_bad = 0;
        while (bus_own && cyc < 1000) begin
            if (sdr_cmd == AREF) nr++;
            if (!sdr_cke) cke_bad++;
            cyc++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL R3 watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int n, cyc, nr, bad, bad2;
        repeat (3) @(negedge clk);
        chk(!ref_req && !bus_own && sdr_cke && !refresh_late && sdr_cmd == NOP,
            "R1 reset outputs", {ref_req, bus_own, sdr_cke, refresh_late}, 4'b0010);
        rst_n = 1'b1;

        // R2 first request timing; R11 stray grant on the way
        n = 0;
        bad = 0;
        while (n < 1000) begin
            @(negedge clk);
            n++;
            if (n == 1) chk(!ref_req && sdr_cmd == NOP, "R1 first cycle", ref_req, 0);
            if (n == 5) ref_gnt = 1'b1;
            if (n == 6) begin
                ref_gnt = 1'b0;
                bad = int'(bus_own) + int'(sdr_cmd != NOP);
            end
            if (ref_req) break;
        end
        chk(bad == 0, "R11 stray grant ignored", bad, 0);
        chk(n == TREFI, "R2 first request", n, TREFI);

        // table-driven refresh scenarios
        for (int i = 0; i < 5; i++) begin
            while (!ref_req) @(negedge clk);
            bad = 0;
            for (int k = 0; k < int'(VEC[i].dly); k++) begin
                @(negedge clk);
                if (!ref_req || bus_own || sdr_cmd != NOP) bad++;
            end
            chk(bad == 0, "R3 request held until grant", bad, 0);
            chk(refresh_late == VEC[i].miss, "R6 late flag at grant",
                refresh_late, VEC[i].miss);
            ref_gnt = 1'b1;
            @(negedge clk);
            ref_gnt = 1'b0;
            chk(sdr_cmd == AREF && sdr_cke && bus_own, "R4 refresh after grant",
                sdr_cmd, AREF);
            own_span(cyc, nr, bad);
            chk(nr == int'(VEC[i].nref), "R6 refresh count", nr, VEC[i].nref);
            chk(cyc == int'(VEC[i].nref) * TRFC && bad == 0, "R5 ownership span",
                cyc, int'(VEC[i].nref) * TRFC);
            chk(!refresh_late, "R6 late cleared", refresh_late, 0);
        end

        // R7 refresh wins over low power
        while (!ref_req) @(negedge clk);
        lp_req = 1'b1;
        ref_gnt = 1'b1;
        @(negedge clk);
        ref_gnt = 1'b0;
        chk(sdr_cmd == AREF && sdr_cke, "R7 refresh before self refresh", sdr_cke, 1);
        own_span(cyc, nr, bad);
        chk(cyc == TRFC && nr == 1, "R7 single refresh", cyc, TRFC);

        // R8 self refresh entry
        chk(ref_req, "R8 low-power request", ref_req, 1);
        ref_gnt = 1'b1;
        @(negedge clk);
        ref_gnt = 1'b0;
        chk(sdr_cmd == AREF && !sdr_cke && bus_own, "R8 entry command", sdr_cke, 0);
        bad = 0;
        bad2 = 0;
        for (int k = 0; k < 2 * TREFI; k++) begin
            @(negedge clk);
            if (sdr_cke || sdr_cmd != NOP || !bus_own) bad++;
            if (ref_req) bad2++;
        end
        chk(bad == 0, "R8 cke held low", bad, 0);
        chk(bad2 == 0, "R10 no request in self refresh", bad2, 0);

        // R9 exit
        lp_req = 1'b0;
        @(negedge clk);
        chk(sdr_cke && sdr_cmd == NOP && bus_own, "R9 cke raised with NOP", sdr_cke, 1);
        own_span(cyc, nr, bad);
        chk(cyc == TRFC && nr == 0 && bad == 0, "R9 exit NOP window", cyc, TRFC);

        // R10 interval restarts
        n = 0;
        while (n < 1000) begin
            @(negedge clk);
            n++;
            if (ref_req) break;
        end
        chk(n == TREFI, "R10 interval restart", n, TREFI);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule